// File: doc/BRIEF.md
# Fast Monitoring Status Encoder

This block drives the four fast-monitoring lines of a trigger board: ready, busy, warning-overflow and out-of-sync. A fifth status, error, has no wire of its own. It is shown by raising ready and busy together, so the two lines carry three states between them: ready, busy and error.

The board is ready only when all of these hold:
- every configuration-done input is high;
- a register-controlled ready bit has been set;
- input alignment has completed;
- data has reached the output of the L1 pipeline.

The ready bit, the alignment flag and the pipeline flag are latched from single-cycle strobes. Each reset kind clears a different subset of them:
- power-on (`rst_n` low) clears all three;
- a hard reset clears all three;
- an L1 reset clears only the alignment and pipeline flags.

After each reset kind, only the conditions it cleared have to be re-established.

Warning-overflow follows a count of outstanding events, which is L1 accepts received minus events shipped to readout. It rises at a programmable high mark and falls below a lower mark, which gives hysteresis. Out-of-sync is the OR of the per-device flags. Every output is a register, and every output reflects the inputs sampled at the clock edge that loads it.

Top module: `fmon_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are rdy=0, bsy=1, wof=0, osy=0, and the ready bit, alignment flag, pipeline flag and outstanding count are all cleared.
- R2: With every `link_sd` bit high, `fm_rdy` is 1 after an edge exactly when, at that edge, every `cfg_done` bit is 1 and the ready bit, alignment flag and pipeline flag are all set. The flags count as set if they were set earlier or are strobed at that edge.
- R3: With every `link_sd` bit high, `fm_bsy` is the complement of `fm_rdy`.
- R4: If any `link_sd` bit is 0 at an edge, both `fm_rdy` and `fm_bsy` are 1 after that edge (error code), whatever the readiness conditions are.
- R5: `fm_osy` after an edge equals the OR of all `osy_flags` bits at that edge.
- R6: An `l1_rst` pulse clears the alignment and pipeline flags but keeps the ready bit. After it, strobing `align_done` and `pipe_filled` alone restores `fm_rdy`.
- R7: A `hard_rst` pulse clears the ready bit as well as the alignment and pipeline flags. `fm_rdy` returns only after `ready_set`, `align_done` and `pipe_filled` have all been strobed again.
- R8: The outstanding count changes once per edge, as follows:
  - it rises by one on `l1a`;
  - it falls by one on `evt_sent`;
  - it is unchanged when both are high;
  - it never goes below 0 and saturates at 2^CNT_W-1.
- R9: `fm_wof` is 1 after any edge at which the updated count is at least `wof_hi`.
- R10: `fm_wof` falls after an edge at which the updated count is below `wof_lo`. Between the two marks it holds its previous value.
- R11: A `hard_rst` or `l1_rst` pulse clears the outstanding count and `fm_wof`.
- R12: When a reset pulse and a set strobe for the same flag arrive at the same edge, the flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hard_rst | input | 1 | Hard reset pulse |
| l1_rst | input | 1 | L1 reset pulse |
| cfg_done | input | N_CFG | Configuration-done levels, one per device |
| ready_set | input | 1 | Strobe that sets the register-controlled ready bit |
| align_done | input | 1 | Strobe: input alignment completed |
| pipe_filled | input | 1 | Strobe: data reached the L1 pipeline output |
| link_sd | input | N_LINK | Signal-detect level per input link |
| osy_flags | input | N_OSY | Out-of-sync flag per device |
| l1a | input | 1 | L1 accept received strobe |
| evt_sent | input | 1 | Event shipped to readout strobe |
| wof_hi | input | CNT_W | Count at which warning-overflow rises |
| wof_lo | input | CNT_W | Count below which warning-overflow falls |
| fm_rdy | output | 1 | Ready line |
| fm_bsy | output | 1 | Busy line |
| fm_wof | output | 1 | Warning-overflow line |
| fm_osy | output | 1 | Out-of-sync line |

## Verification
The ready/busy encoding is driven with a table of level patterns. The patterns include:
- all conditions met;
- a single missing configuration-done bit;
- a single dropped link, with and without the other conditions met;
- several out-of-sync patterns.

Together these separate the three ready/busy states and show that the error code overrides readiness.

Directed sequences then apply each reset kind, followed by the strobes needed to recover. These separate the flags that an L1 reset clears from those that only a hard reset clears.

The overflow warning is exercised by stepping the count across both marks, and by issuing simultaneous accept and ship strobes, a ship strobe at zero, and a run past saturation. Each of these leaves a different mark crossing visible on `fm_wof`.

// File: rtl/fmon_pkg.sv
// Package fmon_pkg
// Shared encoding of the ready/busy line pair. Error is the combination
// ready=1, busy=1; no other wire carries it.
package fmon_pkg;

    typedef struct packed {
        logic rdy;
        logic bsy;
    } fm_pair_t;

    // Map readiness and error onto the two lines; error overrides readiness.
    function automatic fm_pair_t fm_encode(input logic ready, input logic err);
        fm_pair_t p;
        if (err) begin
            p.rdy = 1'b1;
            p.bsy = 1'b1;
        end else begin
            p.rdy = ready;
            p.bsy = ~ready;
        end
        return p;
    endfunction

endpackage

// File: rtl/fmon_ready_track.sv
// Module fmon_ready_track
// Keeps the latched readiness conditions and forms their AND together
// with the configuration-done levels. The ready bit is cleared by
// power-on and hard reset; the alignment and pipeline flags are also
// cleared by L1 reset. A clear wins over a set strobe in the same cycle.
// Assumes strobes and reset pulses are synchronous to clk.
// ready_nxt is the readiness the block holds after the coming edge.
module fmon_ready_track #(
    parameter int N_CFG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_rst,
    input  logic             l1_rst,
    input  logic [N_CFG-1:0] cfg_done,
    input  logic             ready_set,
    input  logic             align_done,
    input  logic             pipe_filled,
    output logic             ready_nxt
);
    logic rbit_q, align_q, pipe_q;
    logic rbit_d, align_d, pipe_d;
    logic clr_soft, clr_hard;

    // Which clears apply this cycle.
    always_comb begin
        clr_hard = hard_rst;
        clr_soft = hard_rst | l1_rst;
    end

    // Next value of each latched condition, clear before set.
    always_comb begin
        rbit_d  = clr_hard ? 1'b0 : (rbit_q  | ready_set);
        align_d = clr_soft ? 1'b0 : (align_q | align_done);
        pipe_d  = clr_soft ? 1'b0 : (pipe_q  | pipe_filled);
    end

    // Condition registers with power-on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbit_q  <= 1'b0;
            align_q <= 1'b0;
            pipe_q  <= 1'b0;
        end else begin
            rbit_q  <= rbit_d;
            align_q <= align_d;
            pipe_q  <= pipe_d;
        end
    end

    // Readiness seen after the edge.
    always_comb ready_nxt = (&cfg_done) & rbit_d & align_d & pipe_d;

    // R6
    l1rst_keeps_rbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_rst && !hard_rst && rbit_q) |=> rbit_q);

    // R7
    hardrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> (!rbit_q && !align_q && !pipe_q));

    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_rst && align_done) |=> !align_q);

endmodule

// File: rtl/fmon_wof_ctr.sv
// Module fmon_wof_ctr
// Counts outstanding events (L1 accepts minus events shipped) and derives
// the warning-overflow flag with hysteresis: set at or above hi, clear
// below lo, hold in between. The count saturates at both ends.
// Assumes lo <= hi; clr is a synchronous pulse.
module fmon_wof_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             l1a,
    input  logic             evt_sent,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             wof_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wof_d;

    // Saturating up/down step of the outstanding count.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (l1a && !evt_sent) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else if (evt_sent && !l1a) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end
    end

    // Hysteresis decision on the updated count.
    always_comb begin
        if (clr)             wof_d = 1'b0;
        else if (cnt_d >= hi) wof_d = 1'b1;
        else if (cnt_d < lo)  wof_d = 1'b0;
        else                  wof_d = wof_q;
    end

    // Count and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wof_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            wof_q <= wof_d;
        end
    end

    // R8
    cnt_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a && !evt_sent && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R8
    cnt_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sent && !l1a && !clr && cnt_q == '0) |=> cnt_q == '0);

    // R9
    wof_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $stable(hi) && cnt_q >= hi) |-> wof_q);

    // R11
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !wof_q));

endmodule

// File: rtl/fmon_fault_merge.sv
// Module fmon_fault_merge
// Reduces the link signal-detect levels to one error condition and the
// per-device out-of-sync flags to one OR. Purely combinational.
module fmon_fault_merge #(
    parameter int N_LINK = 4,
    parameter int N_OSY  = 5
) (
    input  logic [N_LINK-1:0] link_sd,
    input  logic [N_OSY-1:0]  osy_flags,
    output logic              link_err,
    output logic              osy_any
);
    // Any lost link is an error; any flagged device is out of sync.
    always_comb begin
        link_err = ~(&link_sd);
        osy_any  = |osy_flags;
    end
endmodule

// File: rtl/fmon_status.sv
// Module fmon_status
// Top of the fast-monitoring status encoder. Combines readiness, link
// error, out-of-sync and overflow warning into four registered lines.
// Assumes all inputs are synchronous to clk; rst_n is the power-on reset.
module fmon_status
    import fmon_pkg::*;
#(
    parameter int N_CFG  = 3,
    parameter int N_LINK = 4,
    parameter int N_OSY  = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst,
    input  logic              l1_rst,
    input  logic [N_CFG-1:0]  cfg_done,
    input  logic              ready_set,
    input  logic              align_done,
    input  logic              pipe_filled,
    input  logic [N_LINK-1:0] link_sd,
    input  logic [N_OSY-1:0]  osy_flags,
    input  logic              l1a,
    input  logic              evt_sent,
    input  logic [CNT_W-1:0]  wof_hi,
    input  logic [CNT_W-1:0]  wof_lo,
    output logic              fm_rdy,
    output logic              fm_bsy,
    output logic              fm_wof,
    output logic              fm_osy
);
    logic     ready_nxt, link_err, osy_any, wof_q, osy_q;
    fm_pair_t pair_q;

    fmon_ready_track #(.N_CFG(N_CFG)) u_ready (
        .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .l1_rst(l1_rst),
        .cfg_done(cfg_done), .ready_set(ready_set), .align_done(align_done),
        .pipe_filled(pipe_filled), .ready_nxt(ready_nxt)
    );

    fmon_fault_merge #(.N_LINK(N_LINK), .N_OSY(N_OSY)) u_fault (
        .link_sd(link_sd), .osy_flags(osy_flags),
        .link_err(link_err), .osy_any(osy_any)
    );

    fmon_wof_ctr #(.CNT_W(CNT_W)) u_wof (
        .clk(clk), .rst_n(rst_n), .clr(hard_rst | l1_rst), .l1a(l1a),
        .evt_sent(evt_sent), .hi(wof_hi), .lo(wof_lo), .wof_q(wof_q)
    );

    // Output registers for the line pair and out-of-sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '{rdy: 1'b0, bsy: 1'b1};
            osy_q  <= 1'b0;
        end else begin
            pair_q <= fm_encode(ready_nxt, link_err);
            osy_q  <= osy_any;
        end
    end

    // Drive the ports.
    always_comb begin
        fm_rdy = pair_q.rdy;
        fm_bsy = pair_q.bsy;
        fm_wof = wof_q;
        fm_osy = osy_q;
    end

    // R4
    link_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(&link_sd)) |-> (fm_rdy && fm_bsy));

    // R3
    busy_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(&link_sd)) |-> (fm_bsy == !fm_rdy));

    // R5
    osy_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fm_osy == $past(|osy_flags)));

endmodule

// File: tb/fmon_status_bench.sv
module fmon_status_bench;
    localparam int N_CFG = 3, N_LINK = 4, N_OSY = 5, CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n, hard_rst, l1_rst, ready_set, align_done, pipe_filled, l1a, evt_sent;
    logic [N_CFG-1:0]  cfg_done;
    logic [N_LINK-1:0] link_sd;
    logic [N_OSY-1:0]  osy_flags;
    logic [CNT_W-1:0]  wof_hi, wof_lo;
    logic fm_rdy, fm_bsy, fm_wof, fm_osy;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fmon_status u_fmon_status (
        .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .l1_rst(l1_rst),
        .cfg_done(cfg_done), .ready_set(ready_set), .align_done(align_done),
        .pipe_filled(pipe_filled), .link_sd(link_sd), .osy_flags(osy_flags),
        .l1a(l1a), .evt_sent(evt_sent), .wof_hi(wof_hi), .wof_lo(wof_lo),
        .fm_rdy(fm_rdy), .fm_bsy(fm_bsy), .fm_wof(fm_wof), .fm_osy(fm_osy)
    );

    // {cfg_done, link_sd, osy_flags, exp rdy, exp bsy, exp osy}
    localparam logic [14:0] VEC [8] = '{
        {3'b111, 4'b1111, 5'b00000, 3'b100},
        {3'b011, 4'b1111, 5'b00000, 3'b010},
        {3'b111, 4'b1110, 5'b00000, 3'b110},
        {3'b111, 4'b1111, 5'b00100, 3'b101},
        {3'b101, 4'b0111, 5'b10000, 3'b111},
        {3'b111, 4'b1111, 5'b11111, 3'b101},
        {3'b000, 4'b1111, 5'b00001, 3'b011},
        {3'b110, 4'b1011, 5'b00000, 3'b110}
    };

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One clock edge; inputs settle and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
        {hard_rst, l1_rst, ready_set, align_done, pipe_filled, l1a, evt_sent} = '0;
    endtask

    task automatic pulse_l1a(input int n);
        for (int i = 0; i < n; i++) begin
            l1a = 1'b1;
            tick();
        end
    endtask

    task automatic pulse_evt(input int n);
        for (int i = 0; i < n; i++) begin
            evt_sent = 1'b1;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {hard_rst, l1_rst, ready_set, align_done, pipe_filled, l1a, evt_sent} = '0;
        cfg_done = '1;
        link_sd = '1;
        osy_flags = '1;
        wof_hi = 8'd4;
        wof_lo = 8'd2;
        #1;
        tick();
        tick();
        // R1 reset state
        chk("R1 rdy", fm_rdy, 1'b0);
        chk("R1 bsy", fm_bsy, 1'b1);
        chk("R1 wof", fm_wof, 1'b0);
        chk("R1 osy", fm_osy, 1'b0);
        rst_n = 1'b1;
        osy_flags = '0;
        tick();
        chk("R2 not ready before strobes", fm_rdy, 1'b0);

        // Establish the latched conditions, one at a time.
        ready_set = 1'b1;
        tick();
        align_done = 1'b1;
        tick();
        chk("R2 pipe still missing", fm_rdy, 1'b0);
        pipe_filled = 1'b1;
        tick();
        chk("R2 all met", fm_rdy, 1'b1);
        chk("R3 bsy low", fm_bsy, 1'b0);

        // Level-pattern table.
        foreach (VEC[i]) begin
            {cfg_done, link_sd, osy_flags} = VEC[i][14:3];
            tick();
            chk("R2/R4 rdy vector", fm_rdy, VEC[i][2]);
            chk("R3/R4 bsy vector", fm_bsy, VEC[i][1]);
            chk("R5 osy vector", fm_osy, VEC[i][0]);
        end
        cfg_done = '1;
        link_sd = '1;
        osy_flags = '0;
        tick();
        chk("R2 restored", fm_rdy, 1'b1);

        // R6: L1 reset keeps ready bit.
        l1_rst = 1'b1;
        tick();
        chk("R6 cleared by l1 reset", fm_rdy, 1'b0);
        chk("R6 bsy after l1 reset", fm_bsy, 1'b1);
        align_done = 1'b1;
        pipe_filled = 1'b1;
        tick();
        chk("R6 ready without ready_set", fm_rdy, 1'b1);

        // R7: hard reset needs ready_set too.
        hard_rst = 1'b1;
        tick();
        chk("R7 cleared by hard reset", fm_rdy, 1'b0);
        align_done = 1'b1;
        pipe_filled = 1'b1;
        tick();
        chk("R7 align+pipe not enough", fm_rdy, 1'b0);
        ready_set = 1'b1;
        tick();
        chk("R7 ready after ready_set", fm_rdy, 1'b1);

        // R12: clear wins over set in the same cycle.
        hard_rst = 1'b1;
        ready_set = 1'b1;
        align_done = 1'b1;
        pipe_filled = 1'b1;
        tick();
        chk("R12 same-cycle clear wins", fm_rdy, 1'b0);
        align_done = 1'b1;
        pipe_filled = 1'b1;
        tick();
        chk("R12 ready bit stayed clear", fm_rdy, 1'b0);

        // R4 during error with not-ready.
        link_sd = 4'b1101;
        tick();
        chk("R4 err rdy", fm_rdy, 1'b1);
        chk("R4 err bsy", fm_bsy, 1'b1);
        link_sd = '1;

        // WOF with hi=4, lo=2.
        pulse_l1a(3);
        chk("R9 below hi", fm_wof, 1'b0);
        l1a = 1'b1;
        evt_sent = 1'b1;
        tick();
        chk("R8 both strobes hold", fm_wof, 1'b0);
        pulse_l1a(1);
        chk("R9 at hi", fm_wof, 1'b1);
        pulse_evt(1);
        chk("R10 hold at 3", fm_wof, 1'b1);
        pulse_evt(1);
        chk("R10 hold at lo", fm_wof, 1'b1);
        pulse_evt(1);
        chk("R10 below lo", fm_wof, 1'b0);
        pulse_evt(3);
        pulse_l1a(3);
        chk("R8 no underflow, 3 out", fm_wof, 1'b0);
        pulse_l1a(1);
        chk("R8 no underflow, 4 out", fm_wof, 1'b1);

        // R11: L1 reset empties count.
        l1_rst = 1'b1;
        tick();
        chk("R11 wof cleared", fm_wof, 1'b0);
        pulse_l1a(3);
        chk("R11 count restarted", fm_wof, 1'b0);
        hard_rst = 1'b1;
        tick();
        chk("R11 hard reset clears wof", fm_wof, 1'b0);

        // R8 saturation.
        wof_hi = 8'd255;
        wof_lo = 8'd255;
        pulse_l1a(300);
        chk("R8 saturated high", fm_wof, 1'b1);
        pulse_evt(1);
        chk("R8 saturated then one down", fm_wof, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule